// File: doc/BRIEF.md
# Segmented DAC Input Path

This block forms the digital side of an 8-bit segmented digital-to-analog converter. It accepts an 8-bit code, a complement control that is active high, and a latch enable that is active low. It produces the control word for a segmented resistor ladder: seven equal-weight segment lines and five binary lines. The segment lines are a bar-graph encoding of the upper three bits. The five binary lines carry the lower five bits unchanged. A reconstructed 8-bit code is also output so that the encoding can be checked directly.

The output word sits in a register on the system clock. The enable is sampled on each clock edge. While the enable is low, the register loads the encoded input on every cycle, so the outputs follow the input one cycle later. While the enable is high, the register holds its value. For strobed use, a short low pulse on the enable captures the code that was present at the last edge before the enable rose. For free-running use, the enable is tied low and every code passes through. Reset forces zero scale.

Top module: `segdac_frontend`

## Requirements
- R1: When `compIn` is 1, all eight data bits are inverted before encoding; when it is 0 they pass unchanged.
- R2: `codeOut` equals the complemented-or-not input value. Bit 0 has weight 1 and bit 7 has weight 128.
- R3: If the stage-one value has bits 7..5 equal to k, then `segOut[i]` is 1 exactly when i < k. For example, k=3 gives 7'b0000111.
- R4: `binOut[4:0]` equals bits 4..0 of the stage-one value.
- R5: When `latchEnN` is 0 at a rising clock edge, the outputs show that edge's encoded input from that edge until the next.
- R6: When `latchEnN` is 1 at a rising clock edge, the outputs keep their value, whatever `dataIn` and `compIn` do.
- R7: After a low pulse on `latchEnN`, the held word is the input sampled at the last edge that saw the enable low.
- R8: With `latchEnN` tied low, every input code appears at the outputs one cycle later, cycle after cycle.
- R9: A stage-one code of 0x00 gives all segment and binary lines at 0. A code of 0xFF gives all seven segments and all five binary lines at 1.
- R10: `rst` high at an edge clears every output to zero, and it overrides the load.
- R11: `codeOut` always equals 32 × (number of set `segOut` bits) + `binOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 8 | Input code, bit 7 most significant |
| compIn | input | 1 | Inverts all data bits when high |
| latchEnN | input | 1 | Load when low, hold when high |
| segOut | output | 7 | Bar-graph segment lines, lowest first |
| binOut | output | 5 | Binary low-bit lines |
| codeOut | output | 8 | Code reconstructed from the latched word |

## Verification
A full sweep of all 256 codes is run twice in feed-through mode, once with the complement off and once with it on. This separates a wrong bit weight, a segment miscount or a missing inversion from the correct mapping at every value, including the two ends of the scale. Held periods with the data moving separate a register that freezes from one that leaks input. Single low pulses whose data changes on the releasing edge show which edge's data is kept. A reset asserted while the enable is low shows which of reset and load takes priority.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  localparam int DefDataW = 8;
  localparam int DefSegBits = 3;

  typedef struct packed {
    logic clear;
    logic load;
  } segStrobe_t;
endpackage

// File: rtl/segdac_ctrl.sv
module segdac_ctrl
  import segdac_pkg::*;
(
  input  logic       rst,
  input  logic       latchEnN,
  output segStrobe_t strobe
);
  always_comb begin
    strobe.clear = rst;
    strobe.load  = !rst && !latchEnN;
  end
endmodule

// File: rtl/segdac_datapath.sv
module segdac_datapath
  import segdac_pkg::*;
#(
  parameter int DATA_W   = DefDataW,
  parameter int SEG_BITS = DefSegBits
) (
  input  logic                            clk,
  input  segStrobe_t                      strobe,
  input  logic [DATA_W-1:0]               dataIn,
  input  logic                            compIn,
  output logic [(1<<SEG_BITS)-2:0]        segOut,
  output logic [DATA_W-SEG_BITS-1:0]      binOut,
  output logic [DATA_W-1:0]               codeOut
);
  localparam int LOW_W = DATA_W - SEG_BITS;
  localparam int SEG_N = (1 << SEG_BITS) - 1;

  logic [DATA_W-1:0]   trueData;
  logic [SEG_BITS-1:0] topVal;
  logic [SEG_N-1:0]    segNext;
  logic [SEG_N-1:0]    segQ;
  logic [LOW_W-1:0]    binQ;
  logic [SEG_BITS-1:0] segCount;

  assign trueData = dataIn ^ {DATA_W{compIn}};
  assign topVal   = trueData[DATA_W-1:LOW_W];

  for (genvar i = 0; i < SEG_N; i++) begin : g_bar
    assign segNext[i] = (32'(topVal) > i);
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      segQ <= '0;
      binQ <= '0;
    end else if (strobe.load) begin
      segQ <= segNext;
      binQ <= trueData[LOW_W-1:0];
    end
  end

  always_comb begin
    segCount = '0;
    for (int i = 0; i < SEG_N; i++) segCount = segCount + SEG_BITS'(segQ[i]);
  end

  assign segOut  = segQ;
  assign binOut  = binQ;
  assign codeOut = {segCount, binQ};

  assert_reset_zero_R10: assert property (@(posedge clk)
    strobe.clear |=> (segOut == '0) && (binOut == '0));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.load |=> $stable(segOut) && $stable(binOut));

  assert_low_bits_R4: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.load |=> binOut == $past(dataIn[LOW_W-1:0] ^ {LOW_W{compIn}}));

  assert_code_follow_R2: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.load |=> codeOut == $past(dataIn ^ {DATA_W{compIn}}));

  assert_bar_shape_R3: assert property (@(posedge clk) disable iff (strobe.clear)
    ((segOut + SEG_N'(1)) & segOut) == '0);
endmodule

// File: rtl/segdac_frontend.sv
module segdac_frontend
  import segdac_pkg::*;
#(
  parameter int DATA_W   = DefDataW,
  parameter int SEG_BITS = DefSegBits
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DATA_W-1:0]          dataIn,
  input  logic                       compIn,
  input  logic                       latchEnN,
  output logic [(1<<SEG_BITS)-2:0]   segOut,
  output logic [DATA_W-SEG_BITS-1:0] binOut,
  output logic [DATA_W-1:0]          codeOut
);
  segStrobe_t strobe;

  segdac_ctrl u_ctrl (
    .rst      (rst),
    .latchEnN (latchEnN),
    .strobe   (strobe)
  );

  segdac_datapath #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .compIn  (compIn),
    .segOut  (segOut),
    .binOut  (binOut),
    .codeOut (codeOut)
  );
endmodule

// File: tb/segdac_frontend_bench.sv
module segdac_frontend_bench;
  logic       clk = 0;
  logic       rst = 1;
  logic [7:0] dataIn = 8'h00;
  logic       compIn = 0;
  logic       latchEnN = 0;
  logic [6:0] segOut;
  logic [4:0] binOut;
  logic [7:0] codeOut;

  int checks = 0;
  int failures = 0;
  int refCode = 0;
  bit running = 0;

  always #5 clk = ~clk;

  segdac_frontend u_segdac_frontend (
    .clk(clk), .rst(rst), .dataIn(dataIn), .compIn(compIn),
    .latchEnN(latchEnN), .segOut(segOut), .binOut(binOut), .codeOut(codeOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int barOf(input int code);
    int k = code / 32;
    int r = 0;
    for (int i = 0; i < 7; i++) if (i < k) r += (1 << i);
    return r;
  endfunction

  // reference model: updated on each edge from the driven inputs
  always @(posedge clk) begin
    if (rst) refCode <= 0;
    else if (!latchEnN) refCode <= compIn ? (255 - int'(dataIn)) : int'(dataIn);
  end

  // compared on every clock, away from the edge
  always @(negedge clk) begin
    if (running) begin
      chk("R3 segments", int'(segOut), barOf(refCode));
      chk("R4 binary", int'(binOut), refCode % 32);
      chk("R2 code", int'(codeOut), refCode);
      chk("R11 reconstruct", int'(codeOut), 32 * $countones(segOut) + int'(binOut));
    end
  end

  task automatic step(input logic [7:0] d, input logic c, input logic le);
    @(negedge clk);
    dataIn = d; compIn = c; latchEnN = le;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(8'hA5, 0, 0);
    step(8'hA5, 0, 0);
    @(negedge clk);
    chk("R10 reset holds zero", int'({segOut, binOut}), 0);
    rst = 0;
    running = 1;
    // R8 / R1: feed-through sweeps, both complement settings
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < 256; v++) step(8'(v), 1'(c), 0);
    step(8'h0F, 1, 0);
    @(negedge clk);
    chk("R1 complement", int'(codeOut), 8'hF0);
    // R9 end points
    dataIn = 8'h00; compIn = 0;
    @(negedge clk);
    chk("R9 zero scale", int'({segOut, binOut}), 0);
    dataIn = 8'hFF;
    @(negedge clk);
    chk("R9 full scale", int'({segOut, binOut}), 12'hFFF);
    compIn = 1;
    @(negedge clk);
    chk("R9 complemented zero", int'({segOut, binOut}), 0);
    // R5 single edge update, then R6 hold with moving data
    step(8'h5A, 0, 0);
    step(8'hC3, 1, 1);
    chk("R5 one-edge load", int'(codeOut), 8'h5A);
    for (int i = 0; i < 6; i++) begin
      step(8'(i * 37), 1'(i % 2), 1);
      chk("R6 hold ignores input", int'(codeOut), 8'h5A);
    end
    // R7 strobe: data changes together with enable release
    step(8'h33, 0, 0);
    step(8'h33, 0, 0);
    step(8'hEE, 0, 1);
    step(8'h11, 1, 1);
    chk("R7 captured value", int'(codeOut), 8'h33);
    chk("R7 captured segments", int'(segOut), 7'b0000001);
    // R10 reset overrides load
    step(8'h77, 0, 0);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk("R10 reset over load", int'(codeOut), 0);
    rst = 0;
    repeat (3) @(negedge clk);
    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule